// File: doc/BRIEF.md
# Switchable-Direction Clock Fan-out Buffer

This block is a digital model of a clock repeater for a two-wire serial bus. One upstream clock port fans out to four downstream clock ports. Every port is open-drain. The block reads the sampled level of each line and only asserts a pull-low enable; it never drives a line high.

In the forward direction, a low on the upstream line is repeated on every enabled downstream line. When the direction bit is set, the path turns round: the upstream line is pulled low while any enabled downstream line reads low. That is the wired-AND of the enabled downstream lines.

The path never passes a low back toward its own source. A slave that holds the clock low therefore cannot stretch it through the block. A small configuration register holds the direction bit in its top position and one enable bit per channel in its low bits. Software loads it through a write strobe and a data bus.

Top module: `clkfan_top`

## Requirements
- R1: After reset the configuration is all zero (forward direction, every channel disabled), so no pull-low output is asserted whatever the line inputs are.
- R2: In forward direction (bit 7 of the configuration is 0), `dnPullLow[i]` is 1 exactly when channel i is enabled (configuration bit i is 1) and `upIn` is 0.
- R3: In forward direction `upPullLow` stays 0 for every pattern on `dnIn`, so a downstream low never reaches the upstream line.
- R4: In reverse direction (bit 7 is 1), `upPullLow` is 1 exactly when at least one enabled channel has its `dnIn` bit at 0.
- R5: In reverse direction every `dnPullLow` bit stays 0 for every level of `upIn`.
- R6: A disabled channel never asserts its `dnPullLow` bit, and in reverse direction its `dnIn` bit has no effect on `upPullLow`.
- R7: In reverse direction with no channel enabled, `upPullLow` stays 0.
- R8: `cfgWrData` is loaded on a rising clock edge where `cfgWrEn` is 1, and the outputs follow the new value from that edge on. With `cfgWrEn` at 0 the configuration holds. Bits 6 to 4 of the data have no effect.
- R9: A change of the direction bit releases, from the loading edge on, every pull-low that the old direction had asserted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the configuration register |
| rstN | input | 1 | Active-low synchronous reset |
| cfgWrEn | input | 1 | Configuration write strobe |
| cfgWrData | input | 8 | Configuration data: bit 7 direction, bits 3..0 channel enables |
| upIn | input | 1 | Sampled level of the upstream clock line |
| upPullLow | output | 1 | 1 pulls the upstream clock line low |
| dnIn | input | 4 | Sampled levels of the downstream clock lines |
| dnPullLow | output | 4 | 1 pulls the matching downstream clock line low |

## Verification
The assertions assume that `cfgWrEn` and `cfgWrData` are stable around each rising edge. They also assume that the line inputs change only between edges, because the pull-low outputs follow them without a register. The stimulus changes every input a few nanoseconds after a rising edge and compares at the falling edge, once the outputs have settled. The line inputs come from the bench as external levels rather than being looped back from the block's own pull-lows. This keeps the assertion checks free of combinational feedback.

// File: rtl/clkfan_pkg.sv
package clkfan_pkg;
  parameter int CH_N = 4;
  parameter int CFG_W = 8;

  typedef struct packed {
    logic            revMode;
    logic [CH_N-1:0] chanEn;
  } ctrlStrobe_t;
endpackage

// File: rtl/clkfan_ctrl.sv
module clkfan_ctrl
  import clkfan_pkg::*;
#(
  parameter int NUM_CH = CH_N,
  parameter int CFG_BITS = CFG_W
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                wrEn,
  input  logic [CFG_BITS-1:0] wrData,
  output ctrlStrobe_t         strobes
);
  localparam int DIR_POS = CFG_BITS - 1;

  logic              revQ;
  logic [NUM_CH-1:0] enQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      revQ <= 1'b0;
      enQ  <= '0;
    end else if (wrEn) begin
      revQ <= wrData[DIR_POS];
      enQ  <= wrData[NUM_CH-1:0];
    end
  end

  always_comb begin
    strobes.revMode = revQ;
    strobes.chanEn  = enQ;
  end
endmodule

// File: rtl/clkfan_path.sv
module clkfan_path
  import clkfan_pkg::*;
#(
  parameter int NUM_CH = CH_N
) (
  input  ctrlStrobe_t       strobes,
  input  logic              upIn,
  input  logic [NUM_CH-1:0] dnIn,
  output logic              upPullLow,
  output logic [NUM_CH-1:0] dnPullLow
);
  logic [NUM_CH-1:0] lowSeen;

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_chan
    // forward: repeat an upstream low onto enabled lines
    assign dnPullLow[ch] = ~strobes.revMode & strobes.chanEn[ch] & ~upIn;
    // reverse: an enabled line reading low joins the wired-AND
    assign lowSeen[ch]   = strobes.chanEn[ch] & ~dnIn[ch];
  end

  assign upPullLow = strobes.revMode & (|lowSeen);
endmodule

// File: rtl/clkfan_top.sv
module clkfan_top
  import clkfan_pkg::*;
#(
  parameter int NUM_CH = CH_N,
  parameter int CFG_BITS = CFG_W
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                cfgWrEn,
  input  logic [CFG_BITS-1:0] cfgWrData,
  input  logic                upIn,
  output logic                upPullLow,
  input  logic [NUM_CH-1:0]   dnIn,
  output logic [NUM_CH-1:0]   dnPullLow
);
  ctrlStrobe_t       strobes;
  logic              revMode;
  logic [NUM_CH-1:0] chanEn;

  clkfan_ctrl #(.NUM_CH(NUM_CH), .CFG_BITS(CFG_BITS)) u_ctrl (
    .clk(clk), .rstN(rstN), .wrEn(cfgWrEn), .wrData(cfgWrData), .strobes(strobes)
  );

  clkfan_path #(.NUM_CH(NUM_CH)) u_path (
    .strobes(strobes), .upIn(upIn), .dnIn(dnIn),
    .upPullLow(upPullLow), .dnPullLow(dnPullLow)
  );

  assign revMode = strobes.revMode;
  assign chanEn  = strobes.chanEn;
endmodule

// File: rtl/clkfan_chk.sv
module clkfan_chk #(
  parameter int NUM_CH = 4,
  parameter int CFG_BITS = 8
) (
  input logic                clk,
  input logic                rstN,
  input logic                cfgWrEn,
  input logic [CFG_BITS-1:0] cfgWrData,
  input logic                upIn,
  input logic                upPullLow,
  input logic [NUM_CH-1:0]   dnIn,
  input logic [NUM_CH-1:0]   dnPullLow,
  input logic                revMode,
  input logic [NUM_CH-1:0]   chanEn
);
  localparam int DIR_POS = CFG_BITS - 1;

  p_reset_idle_r1: assert property (@(posedge clk)
    $past(!rstN) |-> (!revMode && chanEn == '0));

  p_fwd_copy_r2: assert property (@(posedge clk) disable iff (!rstN)
    !revMode |-> dnPullLow == (chanEn & {NUM_CH{~upIn}}));

  p_fwd_no_back_r3: assert property (@(posedge clk) disable iff (!rstN)
    !revMode |-> !upPullLow);

  p_rev_and_r4: assert property (@(posedge clk) disable iff (!rstN)
    revMode |-> upPullLow == (|(chanEn & ~dnIn)));

  p_rev_dn_idle_r5: assert property (@(posedge clk) disable iff (!rstN)
    revMode |-> dnPullLow == '0);

  p_disabled_quiet_r6: assert property (@(posedge clk) disable iff (!rstN)
    (dnPullLow & ~chanEn) == '0);

  p_none_enabled_r7: assert property (@(posedge clk) disable iff (!rstN)
    (chanEn == '0) |-> !upPullLow);

  p_cfg_load_r8: assert property (@(posedge clk) disable iff (!rstN)
    $past(cfgWrEn) |-> (revMode == $past(cfgWrData[DIR_POS])
                        && chanEn == $past(cfgWrData[NUM_CH-1:0])));

  p_cfg_hold_r8: assert property (@(posedge clk) disable iff (!rstN)
    !$past(cfgWrEn) |-> ($stable(revMode) && $stable(chanEn)));

  p_one_side_r9: assert property (@(posedge clk) disable iff (!rstN)
    !(upPullLow && (|dnPullLow)));
endmodule

bind clkfan_top clkfan_chk #(.NUM_CH(NUM_CH), .CFG_BITS(CFG_BITS)) u_chk (
  .clk(clk), .rstN(rstN), .cfgWrEn(cfgWrEn), .cfgWrData(cfgWrData),
  .upIn(upIn), .upPullLow(upPullLow), .dnIn(dnIn), .dnPullLow(dnPullLow),
  .revMode(revMode), .chanEn(chanEn)
);

// File: tb/clkfan_top_tb.sv
module clkfan_top_tb;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       cfgWrEn = 1'b0;
  logic [7:0] cfgWrData = 8'h00;
  logic       upIn = 1'b1;
  logic [3:0] dnIn = 4'hF;
  logic       upPullLow;
  logic [3:0] dnPullLow;

  int    checks = 0;
  int    failures = 0;
  string phase = "R1";
  bit    mRev = 1'b0;
  int    mEn = 0;
  bit    done = 1'b0;

  always #10 clk = ~clk;

  clkfan_top u_dut (
    .clk(clk), .rstN(rstN), .cfgWrEn(cfgWrEn), .cfgWrData(cfgWrData),
    .upIn(upIn), .upPullLow(upPullLow), .dnIn(dnIn), .dnPullLow(dnPullLow)
  );

  // behavioural reference: configuration state
  always @(posedge clk) begin
    if (!rstN) begin
      mRev = 1'b0;
      mEn  = 0;
    end else if (cfgWrEn) begin
      mRev = cfgWrData[7];
      mEn  = cfgWrData & 8'h0F;
    end
  end

  // compare every cycle at the falling edge
  always @(negedge clk) begin
    int expUp;
    int expDn;
    string tagUp;
    string tagDn;
    expUp = 0;
    expDn = 0;
    if (!mRev) begin
      tagUp = "R3";
      tagDn = "R2";
      for (int i = 0; i < 4; i++)
        if (((mEn >> i) & 1) == 1 && upIn == 1'b0) expDn = expDn | (1 << i);
    end else begin
      tagUp = (mEn == 0) ? "R7" : "R4";
      tagDn = "R5";
      for (int i = 0; i < 4; i++)
        if (((mEn >> i) & 1) == 1 && dnIn[i] == 1'b0) expUp = 1;
    end
    if (!done) begin
      checks++;
      if (int'(upPullLow) != expUp) begin
        failures++;
        $display("FAIL %s (phase %s) upPullLow actual=%0d expected=%0d", tagUp, phase, upPullLow, expUp);
      end
      checks++;
      if (int'(dnPullLow) != expDn) begin
        failures++;
        $display("FAIL %s (phase %s) dnPullLow actual=%h expected=%h", tagDn, phase, dnPullLow, expDn[3:0]);
      end
    end
  end

  task automatic cyc(input logic u, input logic [3:0] d);
    @(posedge clk);
    #4;
    upIn = u;
    dnIn = d;
  endtask

  task automatic wrCfg(input logic [7:0] v);
    @(posedge clk);
    #4;
    cfgWrEn = 1'b1;
    cfgWrData = v;
    @(posedge clk);
    #4;
    cfgWrEn = 1'b0;
    cfgWrData = ~v;
  endtask

  initial begin
    // R1: reset with lines low
    upIn = 1'b0;
    dnIn = 4'h0;
    repeat (3) @(posedge clk);
    #4;
    rstN = 1'b1;
    cyc(1'b0, 4'h0);
    cyc(1'b0, 4'h0);

    // R2, R3: forward, all channels
    phase = "R2";
    wrCfg(8'h0F);
    for (int k = 0; k < 8; k++) cyc(k[0], 4'(k * 3));

    // R6: forward, channels 0 and 2 only
    phase = "R6";
    wrCfg(8'h05);
    for (int k = 0; k < 6; k++) cyc(k[0], 4'(k));

    // R9: forward pulls active, then flip to reverse
    phase = "R9";
    wrCfg(8'h0F);
    cyc(1'b0, 4'hF);
    cyc(1'b0, 4'hF);
    wrCfg(8'h8F);
    cyc(1'b0, 4'hF);

    // R4, R5: reverse, all channels
    phase = "R4";
    for (int k = 0; k < 16; k++) cyc(k[0], 4'(k));

    // R6: reverse, channels 1 and 3
    phase = "R6";
    wrCfg(8'h8A);
    for (int k = 0; k < 16; k++) cyc(1'b0, 4'(k));

    // R7: reverse, none enabled
    phase = "R7";
    wrCfg(8'h80);
    for (int k = 0; k < 16; k++) cyc(1'b0, 4'(k));

    // R8: upper middle bits ignored, holding without strobe
    phase = "R8";
    wrCfg(8'h7F);
    for (int k = 0; k < 4; k++) cyc(k[0], 4'h0);
    cfgWrData = 8'h80;
    cyc(1'b0, 4'h0);
    cyc(1'b0, 4'hE);

    // R9: flip back to forward releases the upstream pull
    phase = "R9";
    wrCfg(8'h83);
    cyc(1'b1, 4'h0);
    wrCfg(8'h03);
    cyc(1'b1, 4'h0);
    cyc(1'b0, 4'h0);

    @(negedge clk);
    #1;
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(200000 * 20);
    failures++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule